// File: doc/BRIEF.md
# Keyboard Matrix Scan and Wake Interrupt Unit

This block sits between a processor and a keyboard matrix. The processor writes a 12-bit output word. Nine of its bits select which matrix rows are driven, and a separate bit drives a one-bit beeper line. The processor reads back an input word. That word combines, with a bitwise OR, the column lines of every driven row. A dedicated power key sits in its top bit, and that key is seen no matter which rows are driven.

A free-running poll timer produces a one-cycle strobe every `TICK_CYCLES` clocks. The default is 1 ms at 100 MHz. On each strobe the unit looks at the keys:

- **Power key pressed.** The unit raises a wake-up pulse and a non-maskable interrupt pulse. It does not run the normal key check for that strobe.
- **Power key not pressed.** The unit compares "any key down" with the key-down flag it stored at the previous check. It raises a wake-up pulse and a maskable interrupt pulse only on a rising edge. A held key therefore interrupts once.
- **Re-arm command.** A one-cycle command clears the stored flag, so a key still held interrupts again at the next strobe.

Every interrupt also sets a sticky service-request bit, which software clears by writing a 1 to it.

Top module: `kbd_scan_irq`

## Requirements
- R1: A cycle with `out_wr_en` high loads `out_wr_data[8:0]` into `row_drive` and `out_wr_data[11]` into `beeper`, visible after that clock edge. Bits 10:9 of the written word have no effect on any output.
- R2: `in_value[14:0]` is the bitwise OR of `col_matrix[r*15 +: 15]` over every row r whose `row_drive[r]` is 1. `in_value[15]` equals `on_key` whatever the rows are, and the whole value follows its inputs in the same cycle.
- R3: `poll_tick` is high for exactly one cycle out of every `TICK_CYCLES` cycles.
- R4: If `on_key` is 1 in a `poll_tick` cycle, then in the next cycle `wake_pulse` and `nmi_pulse` are high and `irq_pulse` is low. The service-request bit is set, and the stored key-down flag is left unchanged.
- R5: If `on_key` is 0 in a `poll_tick` cycle and `in_value` is nonzero while the stored key-down flag is 0, then in the next cycle `wake_pulse` and `irq_pulse` are high and `nmi_pulse` is low. The service-request bit is set.
- R6: On a `poll_tick` cycle with `on_key` 0, the stored key-down flag takes the value (`in_value` != 0). A key held across strobes therefore raises no further pulse, and releasing and pressing again raises a new one.
- R7: A `rearm` pulse clears the stored key-down flag, so a key still held raises `wake_pulse` and `irq_pulse` after the next strobe. If `rearm` coincides with a strobe, that strobe is judged on the old flag and the flag still ends cleared.
- R8: The service-request bit is `status[3]`, and `status[2:0]` reads 0. The bit stays set until a cycle with `status_wr_en` high and `status_wr_data[3]` 1 clears it, and a write with bit 3 at 0 leaves it alone. A set in the same cycle as a clear wins.
- R9: Each interrupt pulse lasts exactly one cycle. Every `irq_pulse` or `nmi_pulse` comes with `wake_pulse`, and the two are never high together.
- R10: After a synchronous active-low reset, the following are all 0: `row_drive`, `beeper`, the stored key-down flag, `status` and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_wr_en | input | 1 | Write strobe for the output word |
| out_wr_data | input | 12 | Output word: rows in 8:0, beeper in 11 |
| status_wr_en | input | 1 | Write strobe for the status nibble |
| status_wr_data | input | 4 | Bit 3 set clears the service request |
| rearm | input | 1 | One-cycle command clearing the key-down flag |
| col_matrix | input | ROWS*COLS | Column lines per row, row r at [r*COLS +: COLS] |
| on_key | input | 1 | Power key, active high |
| row_drive | output | ROWS | Latched row-drive lines |
| beeper | output | 1 | Latched beeper bit |
| in_value | output | COLS+1 | Combined columns, power key in the top bit |
| poll_tick | output | 1 | One-cycle poll strobe |
| wake_pulse | output | 1 | Wake-up pulse |
| irq_pulse | output | 1 | Maskable interrupt pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| status | output | 4 | Status nibble, service request in bit 3 |

## Verification
The assertions check the following on every cycle:
- the row and beeper latch following each write;
- the power key always showing in the input word;
- pulse width and pairing;
- pulses only ever following a strobe;
- the sticky behaviour of the service-request bit.

Edge-only detection, the effect of the re-arm command and the power key bypassing the stored flag depend on history across several strobes. Only the bench's scenarios show these, where a reference model of the flag predicts each strobe's outcome.

// File: rtl/kbd_scan_pkg.sv
// Shared constants and types for the keyboard scan interrupt unit.
// Assumes the output word layout: rows in the low bits, beeper at bit 11.
package kbd_scan_pkg;
    localparam int OUT_W    = 12;
    localparam int BEEP_BIT = 11;
    localparam int STAT_W   = 4;
    localparam int SREQ_BIT = 3;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_KEY  = 2'd1,
        EV_PWR  = 2'd2
    } kbd_event_e;
endpackage

// File: rtl/kbd_row_latch.sv
// Holds the row-drive lines and the beeper bit loaded by processor writes.
// Assumes ROWS does not reach the beeper bit position.
module kbd_row_latch
    import kbd_scan_pkg::*;
#(
    parameter int ROWS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OUT_W-1:0] wr_data,
    output logic [ROWS-1:0]  rows,
    output logic             beep
);
    localparam int GAP_W = BEEP_BIT - ROWS;

    logic [GAP_W-1:0] unused_gap;
    assign unused_gap = wr_data[BEEP_BIT-1:ROWS];

    // Load rows and beeper on each write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows <= '0;
            beep <= 1'b0;
        end else if (wr_en) begin
            rows <= wr_data[ROWS-1:0];
            beep <= wr_data[BEEP_BIT];
        end
    end
endmodule

// File: rtl/kbd_col_combine.sv
// Combines the column lines of all driven rows and appends the power key.
// Purely combinational; assumes the column inputs are already debounced.
module kbd_col_combine #(
    parameter int ROWS = 9,
    parameter int COLS = 15
) (
    input  logic [ROWS-1:0]      rows,
    input  logic [ROWS*COLS-1:0] matrix,
    input  logic                 pwr_key,
    output logic [COLS:0]        value
);
    logic [COLS-1:0] masked [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Gate one row's columns by its drive bit.
        assign masked[r] = rows[r] ? matrix[r*COLS +: COLS] : '0;
    end

    // OR the gated rows together and place the power key on top.
    always_comb begin
        logic [COLS-1:0] acc;
        acc = '0;
        for (int r = 0; r < ROWS; r++) begin
            acc = acc | masked[r];
        end
        value = {pwr_key, acc};
    end
endmodule

// File: rtl/kbd_poll_timer.sv
// Free-running divider producing a one-cycle poll strobe every TICK_CYCLES clocks.
// Assumes TICK_CYCLES is at least 2 so strobes never touch.
module kbd_poll_timer #(
    parameter int TICK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count up and wrap at the last value of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/kbd_event_ctrl.sv
// Decides on each poll strobe whether to interrupt, keeps the key-down flag
// and the sticky service request, and forms the one-cycle pulses.
// Assumes strobes are at least two cycles apart.
module kbd_event_ctrl
    import kbd_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_key,
    input  logic any_down,
    input  logic rearm,
    input  logic clr_req,
    output logic wake,
    output logic irq,
    output logic nmi,
    output logic sreq
);
    kbd_event_e ev;
    logic       kdn_q;

    // Classify the strobe: power key first, otherwise a rising key-down edge.
    always_comb begin
        ev = EV_NONE;
        if (tick) begin
            if (pwr_key)               ev = EV_PWR;
            else if (any_down && !kdn_q) ev = EV_KEY;
        end
    end

    // Track the key-down flag; a re-arm command wins over the strobe update.
    always_ff @(posedge clk) begin
        if (!rst_n)                kdn_q <= 1'b0;
        else if (rearm)            kdn_q <= 1'b0;
        else if (tick && !pwr_key) kdn_q <= any_down;
    end

    // Register the pulses for one cycle after the deciding strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake <= 1'b0;
            irq  <= 1'b0;
            nmi  <= 1'b0;
        end else begin
            wake <= (ev != EV_NONE);
            irq  <= (ev == EV_KEY);
            nmi  <= (ev == EV_PWR);
        end
    end

    // Sticky service request: set by any event, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)              sreq <= 1'b0;
        else if (ev != EV_NONE)  sreq <= 1'b1;
        else if (clr_req)        sreq <= 1'b0;
    end
endmodule

// File: rtl/kbd_scan_irq.sv
// Keyboard matrix scan interrupt unit: row latch, column combining,
// periodic poll and interrupt generation. Assumes synchronous inputs.
module kbd_scan_irq
    import kbd_scan_pkg::*;
#(
    parameter int ROWS        = 9,
    parameter int COLS        = 15,
    parameter int TICK_CYCLES = 100000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_wr_en,
    input  logic [OUT_W-1:0]     out_wr_data,
    input  logic                 status_wr_en,
    input  logic [STAT_W-1:0]    status_wr_data,
    input  logic                 rearm,
    input  logic [ROWS*COLS-1:0] col_matrix,
    input  logic                 on_key,
    output logic [ROWS-1:0]      row_drive,
    output logic                 beeper,
    output logic [COLS:0]        in_value,
    output logic                 poll_tick,
    output logic                 wake_pulse,
    output logic                 irq_pulse,
    output logic                 nmi_pulse,
    output logic [STAT_W-1:0]    status
);
    logic sreq;
    logic any_down;
    logic clr_req;

    kbd_row_latch #(.ROWS(ROWS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (out_wr_en),
        .wr_data (out_wr_data),
        .rows    (row_drive),
        .beep    (beeper)
    );

    kbd_col_combine #(.ROWS(ROWS), .COLS(COLS)) u_comb (
        .rows    (row_drive),
        .matrix  (col_matrix),
        .pwr_key (on_key),
        .value   (in_value)
    );

    kbd_poll_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (poll_tick)
    );

    assign any_down = |in_value;
    assign clr_req  = status_wr_en && status_wr_data[SREQ_BIT];

    kbd_event_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (poll_tick),
        .pwr_key  (on_key),
        .any_down (any_down),
        .rearm    (rearm),
        .clr_req  (clr_req),
        .wake     (wake_pulse),
        .irq      (irq_pulse),
        .nmi      (nmi_pulse),
        .sreq     (sreq)
    );

    // Only the service request is populated in the status nibble.
    always_comb begin
        status           = '0;
        status[SREQ_BIT] = sreq;
    end
endmodule

// File: rtl/kbd_scan_irq_chk.sv
// Cycle-by-cycle checks on the ports of the scan interrupt unit.
module kbd_scan_irq_chk
    import kbd_scan_pkg::*;
#(
    parameter int ROWS = 9,
    parameter int COLS = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_wr_en,
    input logic [OUT_W-1:0]  out_wr_data,
    input logic              status_wr_en,
    input logic [STAT_W-1:0] status_wr_data,
    input logic              on_key,
    input logic [ROWS-1:0]   row_drive,
    input logic              beeper,
    input logic [COLS:0]     in_value,
    input logic              poll_tick,
    input logic              wake_pulse,
    input logic              irq_pulse,
    input logic              nmi_pulse,
    input logic [STAT_W-1:0] status
);
    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(out_wr_en) |-> row_drive == $past(out_wr_data[ROWS-1:0])); // R1
    AST_BEEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(out_wr_en) |-> beeper == $past(out_wr_data[BEEP_BIT])); // R1
    AST_PWR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_value[COLS] == on_key); // R2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        poll_tick |=> !poll_tick); // R3
    AST_WAKE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(poll_tick)); // R4
    AST_IRQ_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> wake_pulse && !nmi_pulse); // R9
    AST_NMI_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> wake_pulse); // R9
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R9
    AST_SREQ_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> status[SREQ_BIT]); // R8
    AST_SREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(status[SREQ_BIT])
        && !($past(status_wr_en) && $past(status_wr_data[SREQ_BIT]))
        |-> status[SREQ_BIT]); // R8
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[SREQ_BIT-1:0] == '0); // R8
endmodule

bind kbd_scan_irq kbd_scan_irq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/sim_kbd_scan_irq.sv
// Bench: directed corner cases plus seeded random strobes against a flag model.
module sim_kbd_scan_irq;
    localparam int ROWS = 9;
    localparam int COLS = 15;
    localparam int TICK = 20;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 out_wr_en = 1'b0;
    logic [11:0]          out_wr_data = '0;
    logic                 status_wr_en = 1'b0;
    logic [3:0]           status_wr_data = '0;
    logic                 rearm = 1'b0;
    logic [ROWS*COLS-1:0] col_matrix = '0;
    logic                 on_key = 1'b0;
    logic [ROWS-1:0]      row_drive;
    logic                 beeper;
    logic [COLS:0]        in_value;
    logic                 poll_tick;
    logic                 wake_pulse, irq_pulse, nmi_pulse;
    logic [3:0]           status;

    int n_chk = 0;
    int n_bad = 0;
    bit m_flag = 1'b0;
    bit m_sreq = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kbd_scan_irq #(.ROWS(ROWS), .COLS(COLS), .TICK_CYCLES(TICK)) u0 (.*);

    function automatic logic [COLS:0] exp_in(logic [ROWS-1:0] r,
                                            logic [ROWS*COLS-1:0] m, logic on);
        logic [COLS-1:0] a = '0;
        for (int i = 0; i < ROWS; i++) if (r[i]) a |= m[i*COLS +: COLS];
        return {on, a};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_out(logic [11:0] d);
        out_wr_en = 1'b1; out_wr_data = d;
        @(negedge clk);
        out_wr_en = 1'b0;
    endtask

    // Wait for a strobe, apply optional rearm/clear in it, check the result.
    task automatic do_tick(bit with_rearm, bit with_clr);
        bit fire_k, fire_p, kd;
        while (!poll_tick) @(negedge clk);
        rearm = with_rearm;
        status_wr_en = with_clr; status_wr_data = with_clr ? 4'h8 : 4'h0;
        fire_p = on_key;
        kd = (exp_in(row_drive, col_matrix, on_key) != 0);
        fire_k = !on_key && kd && !m_flag;
        if (!on_key) m_flag = kd;
        if (with_rearm) m_flag = 1'b0;
        if (fire_k || fire_p) m_sreq = 1'b1;
        else if (with_clr) m_sreq = 1'b0;
        @(negedge clk);
        rearm = 1'b0; status_wr_en = 1'b0; status_wr_data = 4'h0;
        check(wake_pulse == (fire_k | fire_p), "R5 wake", wake_pulse, fire_k | fire_p);
        check(irq_pulse == fire_k, "R5 irq", irq_pulse, fire_k);
        check(nmi_pulse == fire_p, "R4 nmi", nmi_pulse, fire_p);
        check(status[3] == m_sreq, "R8 sreq", status[3], m_sreq);
        @(negedge clk);
        check(!wake_pulse && !irq_pulse && !nmi_pulse, "R9 one cycle",
              {wake_pulse, irq_pulse, nmi_pulse}, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] d;
        logic [31:0] seed;
        int gap;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R10: reset state, sampled while still in reset
        check(row_drive == 0 && beeper == 0 && status == 0, "R10 reset",
              {row_drive, beeper, status}, 0);
        check(!wake_pulse && !irq_pulse && !nmi_pulse, "R10 pulses", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: directed write including ignored bits 10:9
        wr_out(12'hE5A);
        check(row_drive == 9'h05A && beeper == 1'b1, "R1 latch", {beeper, row_drive}, 10'h25A);
        wr_out(12'h600);
        check(row_drive == 0 && beeper == 0, "R1 bits10:9 ignored", {beeper, row_drive}, 0);
        for (int i = 0; i < 10; i++) begin
            d = 12'($urandom);
            wr_out(d);
            check(row_drive == d[8:0] && beeper == d[11], "R1 random",
                  {beeper, row_drive}, {d[11], d[8:0]});
        end

        // R2: combining under random rows/columns/power key
        for (int i = 0; i < 30; i++) begin
            d = 12'($urandom);
            wr_out(d);
            for (int r = 0; r < ROWS; r++) col_matrix[r*COLS +: COLS] = COLS'($urandom);
            on_key = ($urandom % 4) == 0;
            #1;
            check(in_value == exp_in(row_drive, col_matrix, on_key), "R2 combine",
                  in_value, exp_in(row_drive, col_matrix, on_key));
            @(negedge clk);
        end
        wr_out(12'h000);
        on_key = 1'b1; #1;
        check(in_value == 16'h8000, "R2 power with no rows", in_value, 16'h8000);
        on_key = 1'b0;
        col_matrix = '0;

        // R3: strobe period
        while (!poll_tick) @(negedge clk);
        @(negedge clk);
        gap = 1;
        while (!poll_tick) begin @(negedge clk); gap++; end
        check(gap == TICK, "R3 period", gap, TICK);

        // Clear whatever state remains, baseline flag 0
        do_tick(1'b0, 1'b1);
        // R5: rising key edge interrupts
        wr_out(12'h004);
        col_matrix[2*COLS +: COLS] = 15'h0010;
        do_tick(1'b0, 1'b0);
        // R6: held key gives no new interrupt
        do_tick(1'b0, 1'b0);
        // R8: clear with bit 3 at 0 has no effect, with 1 clears
        status_wr_en = 1'b1; status_wr_data = 4'h7; @(negedge clk);
        status_wr_en = 1'b0;
        check(status == 4'h8, "R8 no clear", status, 4'h8);
        status_wr_en = 1'b1; status_wr_data = 4'h8; @(negedge clk);
        status_wr_en = 1'b0;
        check(status == 4'h0, "R8 clear", status, 4'h0);
        m_sreq = 1'b0;
        // R7: rearm between strobes, held key fires again
        rearm = 1'b1; @(negedge clk); rearm = 1'b0; m_flag = 1'b0;
        do_tick(1'b0, 1'b0);
        // R7: rearm coinciding with strobe, then next strobe fires; R8 set wins
        do_tick(1'b1, 1'b1);
        do_tick(1'b0, 1'b1);
        // R4: power key bypasses flag while key held
        on_key = 1'b1;
        do_tick(1'b0, 1'b0);
        do_tick(1'b0, 1'b0);
        on_key = 1'b0;
        // R6: release then press again
        col_matrix = '0;
        do_tick(1'b0, 1'b0);
        col_matrix[2*COLS +: COLS] = 15'h4000;
        do_tick(1'b0, 1'b0);

        // Random strobes against the model (R4 R5 R6 R7 R8)
        for (int i = 0; i < 60; i++) begin
            wr_out(12'($urandom));
            col_matrix = '0;
            if ($urandom % 2 == 0)
                col_matrix[($urandom % (ROWS*COLS))] = 1'b1;
            on_key = ($urandom % 6) == 0;
            if ($urandom % 8 == 0) begin
                rearm = 1'b1; @(negedge clk); rearm = 1'b0; m_flag = 1'b0;
            end
            do_tick(($urandom % 7) == 0, ($urandom % 3) == 0);
        end

        // R10: reset mid-run clears everything
        on_key = 1'b1; do_tick(1'b0, 1'b0); on_key = 1'b0;
        wr_out(12'h9FF);
        rst_n = 1'b0; @(negedge clk);
        check(row_drive == 0 && beeper == 0 && status == 0, "R10 rerun reset",
              {row_drive, beeper, status}, 0);
        rst_n = 1'b1; m_flag = 1'b0; m_sreq = 1'b0;
        wr_out(12'h001);
        col_matrix = '0; col_matrix[0] = 1'b1;
        do_tick(1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule